// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer. A slow tick strobe, nominally 128 kHz, drives a prescaler and a stage counter. When the selected period elapses, the block raises a reset request for one clock. Software restarts the count by pulsing the kick input. A six-bit control register sets the enable, the change-enable flag and a four-bit period code. It is written through a single-cycle write strobe and read back continuously.

A static protection-level input decides which register writes need a timed unlock. At level 1 the watchdog starts disabled. It may be switched on freely, and its period may be changed freely, but it can only be switched off through the unlock. At level 2 the watchdog starts running and can never be stopped, and its period can only be changed through the unlock.

The unlock takes two writes. The opening write sets both the change-enable bit and the enable bit. The closing write must arrive within the next four clock cycles with the change-enable bit clear, and it carries the new values. The change-enable bit reads back as one for as long as the window stays open.

Top module: `wdog_guard`

## Requirements
- R1: After reset, level 1 reads back control value 0 (enable bit0=0, change-enable bit1=0, period bits[5:2]=0). Level 2 reads back enable=1 with the other fields 0.
- R2: At level 1, a plain write (bit1=0) with bit0=1 sets the enable, and the written period is taken as is.
- R3: At level 1, a plain write with bit0=0 while the watchdog is enabled leaves the enable at one.
- R4: A write with bit1=1 and bit0=1 opens a window, and bit1 reads back 1 while it is open. A write with bit1=0 in any of the next four cycles applies the enable (level 1) and the period, then closes the window.
- R5: A closing write made five or more cycles after the opening write is handled as a plain write. Bit1 reads 0 once the window has lapsed.
- R6: A write with bit1=1 and bit0=0 does not open the window.
- R7: At level 2 the enable always reads 1. Plain writes leave the period unchanged. Through the unlock, the period is changed and the written enable value is ignored.
- R8: Period code N gives a timeout of 2^(PSC_W+N) ticks for N up to 9. Codes 10 to 15 behave as code 9.
- R9: A kick restarts the prescaler and the counter. Any change of the period field also restarts the count.
- R10: The reset request is high for exactly one clock, and the next timeout is counted from zero.
- R11: While the watchdog is disabled, no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow tick strobe, one clock wide |
| kick_i | input | 1 | Restart the watchdog count |
| level2_i | input | 1 | Protection level: 0 = level 1, 1 = level 2 (static) |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 6 | Write data: [5:2] period, [1] change-enable, [0] enable |
| rd_data_o | output | 6 | Control register readback, same layout |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Assertions check several properties on every cycle:
- the reset request lasts exactly one clock;
- a kick or a disabled watchdog suppresses the request on the following cycle;
- the stage counter never passes the decoded limit;
- at level 2 the period cannot move outside a window;
- at level 1 the enable cannot drop outside a window;
- a valid opening write always opens the window, and an opening write without the enable bit never does.

Only the bench scenarios can show the exact cycle counts. These are the timeout length for each period code, including the reserved codes. They are also the last cycle at which a closing write is still accepted and the first at which it is refused, and the count left after a kick or a period change.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned PER_W  = 4;

  typedef struct packed {
    logic [PER_W-1:0] period;  // [5:2]
    logic             chg;     // [1]
    logic             en;      // [0]
  } ctrl_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level2_i,
  input  logic             wr_en_i,
  input  ctrl_t            wr_data_i,
  output ctrl_t            ctrl_o,
  output logic             en_o,
  output logic [PER_W-1:0] period_o,
  output logic             per_chg_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] win_q, win_d;
  logic             en_q, en_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             win_open, open_wr, fin_wr;

  assign win_open = (win_q != '0);
  assign open_wr  = wr_en_i & wr_data_i.chg & wr_data_i.en;
  assign fin_wr   = wr_en_i & ~wr_data_i.chg & win_open;

  always_comb begin
    en_d  = en_q;
    per_d = per_q;
    if (!level2_i) begin
      if (fin_wr) begin
        en_d  = wr_data_i.en;
        per_d = wr_data_i.period;
      end else if (wr_en_i) begin
        en_d  = en_q | wr_data_i.en;  // setting is free, clearing is not
        per_d = wr_data_i.period;
      end
    end else if (fin_wr) begin
      per_d = wr_data_i.period;
    end
  end

  always_comb begin
    if (open_wr)       win_d = WIN_W'(WIN_CYC);
    else if (wr_en_i)  win_d = '0;
    else if (win_open) win_d = win_q - WIN_W'(1);
    else               win_d = win_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      en_q  <= 1'b0;
      per_q <= '0;
    end else begin
      win_q <= win_d;
      en_q  <= en_d;
      per_q <= per_d;
    end
  end

  assign en_o      = en_q | level2_i;
  assign period_o  = per_q;
  assign per_chg_o = (per_d != per_q);
  assign ctrl_o    = '{period: per_q, chg: win_open, en: en_o};

  // R4: a valid opening write opens the window
  a_r4_open_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_wr |=> win_open);
  // R6: opening without the enable bit is refused
  a_r6_no_open_without_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i.chg && !wr_data_i.en && !win_open) |=> !win_open);
  // R7: period locked outside the window at level 2
  a_r7_period_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level2_i && !win_open) |=> $stable(per_q));
  // R3: enable cannot drop outside the window at level 1
  a_r3_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level2_i && en_q && !win_open) |=> en_q);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned PSC_W    = 11,
  parameter int unsigned MAX_CODE = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PER_W-1:0] code_i,
  output logic             expire_o
);
  localparam int unsigned STG_W = MAX_CODE;

  logic [PSC_W-1:0] psc_q;
  logic [STG_W-1:0] stg_q, stg_lim;
  logic [PER_W-1:0] code_eff;
  logic [STG_W:0]   one_sh, lim_full;

  // reserved codes saturate to the longest period
  assign code_eff = (code_i > PER_W'(MAX_CODE)) ? PER_W'(MAX_CODE) : code_i;
  assign one_sh   = (STG_W+1)'(1) << code_eff;
  assign lim_full = one_sh - (STG_W+1)'(1);
  assign stg_lim  = lim_full[STG_W-1:0];

  assign expire_o = run_i & tick_i & ~clear_i & (&psc_q) & (stg_q == stg_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      stg_q <= '0;
    end else if (clear_i || !run_i || expire_o) begin
      psc_q <= '0;
      stg_q <= '0;
    end else if (tick_i) begin
      psc_q <= psc_q + PSC_W'(1);
      if (&psc_q) stg_q <= stg_q + STG_W'(1);
    end
  end

  // R8: stage counter stays within the decoded limit
  a_r8_stage_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i) |-> (stg_q <= stg_lim));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned PSC_W    = 11,
  parameter int unsigned MAX_CODE = 9,
  parameter int unsigned WIN_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              level2_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic             en, per_chg, expire, rst_req_q;
  logic [PER_W-1:0] period;

  wdog_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level2_i  (level2_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (ctrl_t'(wr_data_i)),
    .ctrl_o    (ctrl),
    .en_o      (en),
    .period_o  (period),
    .per_chg_o (per_chg)
  );

  wdog_count #(.PSC_W(PSC_W), .MAX_CODE(MAX_CODE)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (en),
    .clear_i  (kick_i | per_chg),
    .code_i   (period),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire;
  end

  assign rd_data_o = ctrl;
  assign rst_req_o = rst_req_q;

  // R10: single-cycle reset request
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R9: a kick suppresses the request on the next cycle
  a_r9_kick_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !rst_req_o);
  // R11: no request while disabled
  a_r11_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !rst_req_o);
endmodule

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
  localparam int unsigned PSC_W = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       level2_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_data_i = '0;
  logic [5:0] rd_data_o;
  logic       rst_req_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  wdog_guard #(.PSC_W(PSC_W), .MAX_CODE(9), .WIN_CYC(4)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
    .level2_i(level2_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [5:0] mk(input int per, input bit chg, input bit en);
    return {per[3:0], chg, en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic do_write(input logic [5:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic apply_reset(input bit lvl2);
    rst_ni = 1'b0; level2_i = lvl2; tick_i = 1'b0; kick_i = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic to_pulse(output int n);
    n = 0;
    forever begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      if (rst_req_o || n > 5000) break;
    end
  endtask

  task automatic kick_measure(output int n);
    kick_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    kick_i = 1'b0;
    to_pulse(n);
  endtask

  task automatic t_reset;
    apply_reset(1'b0);
    chk("R1 level1 reset value", rd_data_o, 0);
    apply_reset(1'b1);
    chk("R1 level2 reset value", rd_data_o, mk(0, 0, 1));
  endtask

  task automatic t_level1_config;
    apply_reset(1'b0);
    do_write(mk(5, 0, 1));
    chk("R2 plain enable", rd_data_o, mk(5, 0, 1));
    do_write(mk(5, 0, 0));
    chk("R3 plain clear refused", rd_data_o, mk(5, 0, 1));
    do_write(mk(5, 1, 0));
    chk("R6 open without en refused", rd_data_o, mk(5, 0, 1));
    do_write(mk(5, 0, 0));
    chk("R6 clear after bad open refused", rd_data_o, mk(5, 0, 1));
    do_write(mk(5, 1, 1));
    chk("R4 window reads open", rd_data_o, mk(5, 1, 1));
    idle(3);
    chk("R4 window still open at 4th cycle", rd_data_o, mk(5, 1, 1));
    do_write(mk(2, 0, 0));
    chk("R4 unlock clears enable", rd_data_o, mk(2, 0, 0));
    do_write(mk(2, 0, 1));
    do_write(mk(2, 1, 1));
    idle(4);
    chk("R5 window lapsed", rd_data_o, mk(2, 0, 1));
    do_write(mk(3, 0, 0));
    chk("R5 late write refused", rd_data_o, mk(3, 0, 1));
  endtask

  task automatic t_level2_config;
    apply_reset(1'b1);
    do_write(mk(6, 0, 0));
    chk("R7 plain period write refused", rd_data_o, mk(0, 0, 1));
    do_write(mk(0, 1, 1));
    do_write(mk(6, 0, 0));
    chk("R7 unlock sets period, en stays", rd_data_o, mk(6, 0, 1));
    do_write(mk(6, 1, 1));
    idle(4);
    do_write(mk(3, 0, 1));
    chk("R7 late period write refused", rd_data_o, mk(6, 0, 1));
  endtask

  task automatic t_timing;
    int n;
    apply_reset(1'b0);
    tick_i = 1'b1;
    do_write(mk(0, 0, 1));
    kick_measure(n);
    chk("R8 code 0 timeout", n, 4);
    chk("R10 pulse high", rst_req_o, 1);
    idle(1);
    chk("R10 pulse one cycle", rst_req_o, 0);
    to_pulse(n);
    chk("R10 next timeout from zero", n, 3);
    do_write(mk(3, 0, 1));
    kick_measure(n);
    chk("R8 code 3 timeout", n, 32);
    do_write(mk(9, 0, 1));
    kick_measure(n);
    chk("R8 code 9 timeout", n, 2048);
    do_write(mk(12, 0, 1));
    kick_measure(n);
    chk("R8 reserved code 12 as 9", n, 2048);
    do_write(mk(0, 0, 1));
    kick_i = 1'b1; idle(1); kick_i = 1'b0;
    idle(3);
    kick_measure(n);
    chk("R9 kick restarts count", n, 4);
    do_write(mk(1, 0, 1));
    kick_i = 1'b1; idle(1); kick_i = 1'b0;
    idle(5);
    do_write(mk(0, 0, 1));
    to_pulse(n);
    chk("R9 period change restarts", n, 4);
    tick_i = 1'b0;
  endtask

  task automatic t_disabled;
    int hits = 0;
    apply_reset(1'b0);
    tick_i = 1'b1;
    repeat (200) begin
      @(negedge clk_i);
      if (rst_req_o) hits++;
    end
    tick_i = 1'b0;
    chk("R11 no request while disabled", hits, 0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_level1_config();
    t_level2_config();
    t_timing();
    t_disabled();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule